// File: doc/BRIEF.md
# TF32 Multiplier with Single-Precision Result

This block multiplies two reduced-precision floating-point operands and returns an IEEE single-precision product. Each operand has 1 sign bit, an 8-bit exponent with bias 127 and a 10-bit stored mantissa. It is carried in the low 19 bits of a 32-bit word, and the upper bits of the word play no part in the result. The block restores the hidden bit, or normalises a subnormal input, and then multiplies the two 11-bit significands. It normalises, rounds and packs the product and raises five exception flags.

Two 11-bit significands give a 22-bit product, which always fits the 24-bit single-precision significand. A result in the normal range is therefore exact. Rounding takes place only when the exponent leaves the normal range: on overflow, or when the result becomes subnormal or zero. The block is fully pipelined and accepts one operand pair per cycle. The multiply part and the round part each have their own depth parameter, and a result appears after the sum of the two depths.

Top module: `tf32_fp32_mul`

## Requirements
- R1: An operand word holds its sign in bit 18, its exponent in bits [17:10] and its mantissa in bits [9:0]. Bits [31:19] of either operand have no effect on the result or the flags.
- R2: When both operands are finite and nonzero and the product lies in the single-precision normal range, the result equals the exact product, and all flags are zero.
- R3: `out_valid` goes high exactly MUL_STAGES+RND_STAGES cycles after each cycle in which `in_valid` is high. One operand pair is accepted every cycle. After reset, `out_valid`, `result` and `flags` are all zero.
- R4: The result sign is the XOR of the two operand signs, and this holds for zero and infinity results too. A zero times a finite value gives a signed zero with no flags. An infinity times a nonzero value gives a signed infinity with no flags.
- R5: An operand with exponent field 0 and a nonzero mantissa m has the value m·2^-136 and is multiplied at its full precision.
- R6: A NaN operand (exponent 255, mantissa nonzero), or an infinity multiplied by a zero, gives 32'h7FC00000 and sets only the invalid flag.
- R7: On exponent overflow the result is either infinity or the largest finite magnitude 0x7F7FFFFF with the product's sign. Round-to-nearest modes give infinity. Toward-zero gives the largest finite value. Downward gives infinity only for a negative result. Upward gives infinity only for a positive result. The overflow and inexact flags are set.
- R8: A product below 2^-126 is rounded to a subnormal or to zero in the selected mode. When that rounding loses bits, the underflow and inexact flags are set. An exactly representable subnormal result sets no flag.
- R9: Flag bits are: bit 4 invalid, bit 3 divide-by-zero (always 0), bit 2 overflow, bit 1 underflow, bit 0 inexact. The invalid flag never appears together with another flag.
- R10: `rnd_mode` encodes 0 nearest-even, 1 toward zero, 2 downward, 3 upward, 4 nearest with ties away from zero. The values 5 to 7 act as nearest-even.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand pair and rounding mode are valid this cycle |
| rnd_mode | input | 3 | Rounding mode selector |
| op_a | input | 32 | First operand, format in bits [18:0] |
| op_b | input | 32 | Second operand, format in bits [18:0] |
| out_valid | output | 1 | Result and flags are valid this cycle |
| result | output | 32 | Single-precision product |
| flags | output | 5 | Exception flags |

## Verification
Two functions can act in the same cycle: a new operand pair enters the multiply stages while an earlier pair's rounding and flag generation completes at the output. The bench provokes this with back-to-back streams that mix normal products with overflow, NaN and underflow cases. Each result is matched in issue order against an expectation worked out by hand, so a flag or result that leaks between neighbouring pairs is caught. Random normal-range products are judged against a real-number model that decodes both operands and the result.

// File: rtl/tf32_mul_pkg.sv
// Shared constants and types for the reduced-precision multiplier.
// Assumes operands carry a 1/8/10 sign/exponent/mantissa layout in bits [18:0].
package tf32_mul_pkg;

    localparam int OP_MAN_W   = 10;
    localparam int OP_EXP_W   = 8;
    localparam int OP_SIG_W   = OP_MAN_W + 1;
    localparam int PROD_W     = 2 * OP_SIG_W;
    localparam int EXP_W      = 11;
    localparam int BIAS       = 127;
    localparam int SUB_BASE   = 1 - BIAS - OP_MAN_W;
    localparam int SIGN_POS   = OP_MAN_W + OP_EXP_W;
    localparam int OUT_FRAC_W = 23;

    localparam int FLAG_NV = 4;
    localparam int FLAG_DZ = 3;
    localparam int FLAG_OF = 2;
    localparam int FLAG_UF = 1;
    localparam int FLAG_NX = 0;

    localparam logic [31:0] QNAN_BITS = 32'h7FC0_0000;

    typedef enum logic [2:0] {
        RM_NEAR_EVEN = 3'd0,
        RM_TO_ZERO   = 3'd1,
        RM_DOWN      = 3'd2,
        RM_UP        = 3'd3,
        RM_NEAR_MAX  = 3'd4
    } rnd_mode_e;

    typedef enum logic [1:0] {
        CLS_ZERO,
        CLS_FINITE,
        CLS_INF,
        CLS_NAN
    } op_class_e;

    typedef struct packed {
        logic                sign;
        op_class_e           cls;
        logic [EXP_W-1:0]    exp;   // unbiased, two's complement
        logic [OP_SIG_W-1:0] sig;   // leading one at bit OP_SIG_W-1 when finite
    } op_fields_t;

    typedef struct packed {
        logic              sign;
        logic              nan;
        logic              inf;
        logic              zero;
        logic [EXP_W-1:0]  exp_sum;
        logic [PROD_W-1:0] prod;
        logic [2:0]        rm;
    } mul_stage_t;

endpackage

// File: rtl/tf32_unpack.sv
// Operand decoder: splits a packed operand into sign, class, unbiased
// exponent and a significand whose leading one sits at the top bit.
// Subnormal inputs are normalised here so later stages see one form only.
module tf32_unpack
    import tf32_mul_pkg::*;
(
    input  logic [SIGN_POS:0] word,
    output op_fields_t        fields
);

    logic [OP_EXP_W-1:0] exp_field;
    logic [OP_MAN_W-1:0] man_field;
    int                  top_bit;

    assign exp_field = word[SIGN_POS-1:OP_MAN_W];
    assign man_field = word[OP_MAN_W-1:0];

    // Classify the operand and produce its normalised significand and exponent.
    always_comb begin
        fields      = '0;
        fields.sign = word[SIGN_POS];
        fields.cls  = CLS_FINITE;
        top_bit     = 0;
        if (exp_field == '1) begin
            fields.cls = (man_field == '0) ? CLS_INF : CLS_NAN;
        end else if (exp_field == '0) begin
            if (man_field == '0) begin
                fields.cls = CLS_ZERO;
            end else begin
                for (int i = 0; i < OP_MAN_W; i++) begin
                    if (man_field[i]) top_bit = i;
                end
                fields.sig = OP_SIG_W'({1'b0, man_field} << (OP_MAN_W - top_bit));
                fields.exp = EXP_W'(top_bit + SUB_BASE);
            end
        end else begin
            fields.sig = {1'b1, man_field};
            fields.exp = EXP_W'(int'(exp_field) - BIAS);
        end
    end

endmodule

// File: rtl/tf32_pipe.sv
// Delay line of DEPTH registered stages with a valid bit per stage.
// The data registers load only when their stage receives a valid entry.
// Assumes DEPTH >= 1.
module tf32_pipe #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data
);

    logic [DEPTH-1:0] vld;
    logic [WIDTH-1:0] dat [DEPTH];

    // Advance valid bits every cycle; move data only behind a valid entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
            for (int s = 0; s < DEPTH; s++) dat[s] <= '0;
        end else begin
            vld[0] <= in_valid;
            if (in_valid) dat[0] <= in_data;
            for (int s = 1; s < DEPTH; s++) begin
                vld[s] <= vld[s-1];
                if (vld[s-1]) dat[s] <= dat[s-1];
            end
        end
    end

    assign out_valid = vld[DEPTH-1];
    assign out_data  = dat[DEPTH-1];

endmodule

// File: rtl/fp32_round_pack.sv
// Normaliser, rounder and packer for the 22-bit significand product.
// Normal-range results are exact. Only the subnormal and overflow paths
// consult the rounding mode. Purely combinational.
module fp32_round_pack
    import tf32_mul_pkg::*;
(
    input  mul_stage_t  stage,
    output logic [31:0] res_bits,
    output logic [4:0]  res_flags
);

    localparam int W_BITS = 48;
    localparam int W_PAD  = W_BITS - PROD_W;
    localparam int RSH0   = W_PAD - 1;          // right shift for biased exponent 0

    logic [PROD_W-1:0]       n_sig;
    logic signed [EXP_W-1:0] e_out;
    logic [W_BITS-1:0]       wide;
    logic [OUT_FRAC_W:0]     shifted;
    logic [OUT_FRAC_W-1:0]   frac;
    logic                    guard, sticky, incr, to_inf;
    logic [OUT_FRAC_W:0]     mag;
    int                      rsh;

    // Bring the product to a leading one at its top bit and bias the exponent.
    always_comb begin
        n_sig = stage.prod[PROD_W-1] ? stage.prod : (stage.prod << 1);
        e_out = $signed(stage.exp_sum) + EXP_W'(BIAS) + EXP_W'(stage.prod[PROD_W-1]);
        wide  = {n_sig, W_PAD'(0)};
    end

    // Denormalising shift for tiny results: truncated fraction, guard and sticky.
    always_comb begin
        rsh     = RSH0 - int'(e_out);
        shifted = '0;
        frac    = '0;
        guard   = 1'b0;
        sticky  = 1'b0;
        if (rsh > W_BITS) begin
            sticky = 1'b1;
        end else if (rsh > 0) begin
            shifted = (OUT_FRAC_W+1)'(wide >> (rsh - 1));
            frac    = shifted[OUT_FRAC_W:1];
            guard   = shifted[0];
            sticky  = |(wide & ((W_BITS'(1) << (rsh - 1)) - W_BITS'(1)));
        end
    end

    // Rounding decisions for the tiny path (incr) and the overflow path (to_inf).
    always_comb begin
        case (rnd_mode_e'(stage.rm))
            RM_TO_ZERO:  begin incr = 1'b0;                            to_inf = 1'b0;        end
            RM_DOWN:     begin incr = stage.sign & (guard | sticky);   to_inf = stage.sign;  end
            RM_UP:       begin incr = ~stage.sign & (guard | sticky);  to_inf = ~stage.sign; end
            RM_NEAR_MAX: begin incr = guard;                           to_inf = 1'b1;        end
            default:     begin incr = guard & (sticky | frac[0]);      to_inf = 1'b1;        end
        endcase
        mag = {1'b0, frac} + (OUT_FRAC_W+1)'(incr);
    end

    // Select the packed result and flags by operand class and exponent range.
    always_comb begin
        res_flags = '0;
        if (stage.nan) begin
            res_bits          = QNAN_BITS;
            res_flags[FLAG_NV] = 1'b1;
        end else if (stage.inf) begin
            res_bits = {stage.sign, 8'hFF, 23'd0};
        end else if (stage.zero) begin
            res_bits = {stage.sign, 31'd0};
        end else if (e_out >= 255) begin
            res_bits           = {stage.sign, to_inf ? 31'h7F80_0000 : 31'h7F7F_FFFF};
            res_flags[FLAG_OF] = 1'b1;
            res_flags[FLAG_NX] = 1'b1;
        end else if (e_out >= 1) begin
            res_bits = {stage.sign, e_out[7:0], n_sig[PROD_W-2:0], 2'b00};
        end else begin
            res_bits           = {stage.sign, 7'd0, mag};
            res_flags[FLAG_UF] = guard | sticky;
            res_flags[FLAG_NX] = guard | sticky;
        end
    end

endmodule

// File: rtl/tf32_fp32_mul.sv
// Pipelined multiplier: two reduced-precision operands in, one
// single-precision product and five flags out after MUL_STAGES+RND_STAGES cycles.
// Assumes both stage parameters are at least 1. Accepts one pair per cycle.
module tf32_fp32_mul
    import tf32_mul_pkg::*;
#(
    parameter int MUL_STAGES = 2,
    parameter int RND_STAGES = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [2:0]  rnd_mode,
    input  logic [31:0] op_a,
    input  logic [31:0] op_b,
    output logic        out_valid,
    output logic [31:0] result,
    output logic [4:0]  flags
);

    localparam int OUT_W = 32 + 5;

    logic [SIGN_POS:0] words [2];
    op_fields_t        opf   [2];
    mul_stage_t        mul_d, mul_q;
    logic              mul_vld;
    logic [31:0]       rp_bits;
    logic [4:0]        rp_flags;
    logic [OUT_W-1:0]  out_bus;
    logic              unused_hi_bits;

    assign words[0]       = op_a[SIGN_POS:0];
    assign words[1]       = op_b[SIGN_POS:0];
    assign unused_hi_bits = ^{op_a[31:SIGN_POS+1], op_b[31:SIGN_POS+1]};

    for (genvar gi = 0; gi < 2; gi++) begin : g_unpack
        tf32_unpack u_unpack (
            .word   (words[gi]),
            .fields (opf[gi])
        );
    end

    // Combine the two decoded operands: classify, multiply and sum exponents.
    always_comb begin
        mul_d         = '0;
        mul_d.sign    = opf[0].sign ^ opf[1].sign;
        mul_d.nan     = (opf[0].cls == CLS_NAN) || (opf[1].cls == CLS_NAN) ||
                        ((opf[0].cls == CLS_INF) && (opf[1].cls == CLS_ZERO)) ||
                        ((opf[0].cls == CLS_ZERO) && (opf[1].cls == CLS_INF));
        mul_d.inf     = !mul_d.nan && ((opf[0].cls == CLS_INF) || (opf[1].cls == CLS_INF));
        mul_d.zero    = !mul_d.nan && ((opf[0].cls == CLS_ZERO) || (opf[1].cls == CLS_ZERO));
        mul_d.exp_sum = opf[0].exp + opf[1].exp;
        mul_d.prod    = opf[0].sig * opf[1].sig;
        mul_d.rm      = rnd_mode;
    end

    tf32_pipe #(
        .WIDTH ($bits(mul_stage_t)),
        .DEPTH (MUL_STAGES)
    ) u_mul_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (mul_d),
        .out_valid (mul_vld),
        .out_data  (mul_q)
    );

    fp32_round_pack u_round (
        .stage     (mul_q),
        .res_bits  (rp_bits),
        .res_flags (rp_flags)
    );

    tf32_pipe #(
        .WIDTH (OUT_W),
        .DEPTH (RND_STAGES)
    ) u_rnd_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (mul_vld),
        .in_data   ({rp_bits, rp_flags}),
        .out_valid (out_valid),
        .out_data  (out_bus)
    );

    assign {result, flags} = out_bus;

endmodule

// File: rtl/tf32_mul_chk.sv
// Property checker for the multiplier, attached to every instance by bind.
// Keeps its own record of issue cycles to judge the output timing.
module tf32_mul_chk
    import tf32_mul_pkg::*;
#(
    parameter int LATENCY = 3
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        out_valid,
    input logic [31:0] result,
    input logic [4:0]  flags
);

    logic [LATENCY-1:0] issued;

    // Record which recent cycles carried an operand pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issued <= '0;
        end else begin
            issued[0] <= in_valid;
            for (int i = 1; i < LATENCY; i++) issued[i] <= issued[i-1];
        end
    end

    assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == issued[LATENCY-1]);

    assert_nan_canonical_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && result[30:23] == 8'hFF && result[22:0] != 23'd0)
        |-> (result == QNAN_BITS && flags[FLAG_NV]));

    assert_invalid_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flags[FLAG_NV]) |-> result == QNAN_BITS);

    assert_no_divzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !flags[FLAG_DZ]);

    assert_invalid_alone_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flags[FLAG_NV]) |-> flags[FLAG_OF:FLAG_NX] == 3'b000);

    assert_overflow_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flags[FLAG_OF]) |->
        (flags[FLAG_NX] && (result[30:0] == 31'h7F80_0000 || result[30:0] == 31'h7F7F_FFFF)));

    assert_underflow_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flags[FLAG_UF]) |-> (flags[FLAG_NX] && result[30:23] <= 8'd1));

endmodule

bind tf32_fp32_mul tf32_mul_chk #(
    .LATENCY (MUL_STAGES + RND_STAGES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .result    (result),
    .flags     (flags)
);

// File: tb/sim_tf32_fp32_mul.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_tf32_fp32_mul;

    localparam int MUL_ST = 2;
    localparam int RND_ST = 1;
    localparam int LAT    = MUL_ST + RND_ST;

    // Operand encodings: sign bit 18, exponent [17:10], mantissa [9:0]
    localparam logic [31:0] ONE_P5   = 32'h0001_FE00;  //  1.5
    localparam logic [31:0] NEG1_P5  = 32'h0005_FE00;  // -1.5
    localparam logic [31:0] ONE      = 32'h0001_FC00;  //  1.0
    localparam logic [31:0] TWO      = 32'h0002_0000;  //  2.0
    localparam logic [31:0] NEG_TWO  = 32'h0006_0000;  // -2.0
    localparam logic [31:0] P_ZERO   = 32'h0000_0000;
    localparam logic [31:0] N_ZERO   = 32'h0004_0000;
    localparam logic [31:0] P_INF    = 32'h0003_FC00;
    localparam logic [31:0] N_INF    = 32'h0007_FC00;
    localparam logic [31:0] A_NAN    = 32'h0003_FC01;
    localparam logic [31:0] P2_127   = 32'h0003_F800;
    localparam logic [31:0] N2_127   = 32'h0007_F800;
    localparam logic [31:0] P2_64    = 32'h0002_FC00;
    localparam logic [31:0] P2_63    = 32'h0002_F800;
    localparam logic [31:0] P2_M63   = 32'h0001_0000;
    localparam logic [31:0] P2_M64   = 32'h0000_FC00;
    localparam logic [31:0] P2_M75   = 32'h0000_D000;
    localparam logic [31:0] N2_M75   = 32'h0004_D000;
    localparam logic [31:0] P1P5_M75 = 32'h0000_D200;
    localparam logic [31:0] P2_100   = 32'h0003_8C00;
    localparam logic [31:0] SUB_MIN  = 32'h0000_0001;  // 2^-136
    localparam logic [31:0] SUB_300  = 32'h0000_0300;  // 1.5 * 2^-127

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  rnd_mode = 3'd0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        out_valid;
    logic [31:0] result;
    logic [4:0]  flags;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    tf32_fp32_mul #(
        .MUL_STAGES (MUL_ST),
        .RND_STAGES (RND_ST)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .rnd_mode  (rnd_mode),
        .op_a      (op_a),
        .op_b      (op_b),
        .out_valid (out_valid),
        .result    (result),
        .flags     (flags)
    );

    function automatic real pow2(int k);
        real r = 1.0;
        if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
        else        for (int i = 0; i < -k; i++) r = r / 2.0;
        return r;
    endfunction

    function automatic real op_value(logic [31:0] w);
        real v;
        if (w[17:10] == 8'd0) v = real'(w[9:0]) * pow2(-136);
        else                  v = real'(32'd1024 + w[9:0]) * pow2(int'(w[17:10]) - 137);
        return w[18] ? -v : v;
    endfunction

    function automatic real fp32_value(logic [31:0] w);
        real v;
        if (w[30:23] == 8'd0) v = real'(w[22:0]) * pow2(-149);
        else                  v = real'(32'h0080_0000 + w[22:0]) * pow2(int'(w[30:23]) - 150);
        return w[31] ? -v : v;
    endfunction

    task automatic check_bits(input string tag, input logic [31:0] got_r, input logic [4:0] got_f,
                              input logic [31:0] exp_r, input logic [4:0] exp_f);
        n_checks++;
        if (got_r !== exp_r || got_f !== exp_f) begin
            n_fail++;
            $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
                     tag, got_r, got_f, exp_r, exp_f);
        end
    endtask

    task automatic check_bit(input string tag, input logic got, input logic exp_v);
        n_checks++;
        if (got !== exp_v) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, exp_v);
        end
    endtask

    // Issue one pair, wait for the pipeline, and sample the output.
    task automatic do_op(input logic [31:0] a, input logic [31:0] b, input logic [2:0] rm,
                         output logic [31:0] r, output logic [4:0] f, output logic v);
        @(negedge clk);
        op_a = a; op_b = b; rnd_mode = rm; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (LAT - 1) @(negedge clk);
        v = out_valid; r = result; f = flags;
    endtask

    task automatic expect_op(input string tag, input logic [31:0] a, input logic [31:0] b,
                             input logic [2:0] rm, input logic [31:0] er, input logic [4:0] ef);
        logic [31:0] r;
        logic [4:0]  f;
        logic        v;
        do_op(a, b, rm, r, f, v);
        check_bit({tag, " valid"}, v, 1'b1);
        check_bits(tag, r, f, er, ef);
    endtask

    task automatic test_reset_r3();
        check_bit("R3 reset out_valid", out_valid, 1'b0);
        check_bits("R3 reset outputs", result, flags, 32'h0, 5'h0);
    endtask

    task automatic test_normal_r2();
        expect_op("R2 1.5*1.5", ONE_P5, ONE_P5, 3'd0, 32'h4010_0000, 5'h00);
        expect_op("R2 2^64*2^63", P2_64, P2_63, 3'd1, 32'h7F00_0000, 5'h00);
        for (int k = 0; k < 40; k++) begin
            logic [31:0] a, b, r;
            logic [4:0]  f;
            logic        v;
            real         want;
            a = {13'($urandom()), 1'($urandom()), 8'($urandom_range(180, 70)), 10'($urandom())};
            b = {13'($urandom()), 1'($urandom()), 8'($urandom_range(180, 70)), 10'($urandom())};
            want = op_value(a) * op_value(b);
            do_op(a, b, 3'($urandom_range(4, 0)), r, f, v);
            n_checks++;
            if (!v || fp32_value(r) != want || f !== 5'h0) begin
                n_fail++;
                $display("FAIL R2 random %0d: result=%h flags=%b expected value %e flags=00000",
                         k, r, f, want);
            end
        end
    endtask

    task automatic test_ignore_r1();
        expect_op("R1 high bits set", 32'hFFF9_FE00, 32'hA5A9_FE00, 3'd0, 32'h4010_0000, 5'h00);
        expect_op("R1 high bits on inf", 32'hFFFB_FC00, P_ZERO, 3'd0, 32'h7FC0_0000, 5'h10);
    endtask

    task automatic test_sign_r4();
        expect_op("R4 neg*pos", NEG1_P5, ONE_P5, 3'd0, 32'hC010_0000, 5'h00);
        expect_op("R4 -0*2", N_ZERO, TWO, 3'd0, 32'h8000_0000, 5'h00);
        expect_op("R4 -0*-0", N_ZERO, N_ZERO, 3'd0, 32'h0000_0000, 5'h00);
        expect_op("R4 inf*-2", P_INF, NEG_TWO, 3'd0, 32'hFF80_0000, 5'h00);
        expect_op("R4 -inf*-inf", N_INF, N_INF, 3'd0, 32'h7F80_0000, 5'h00);
    endtask

    task automatic test_subnormal_in_r5();
        expect_op("R5 2^-136*2^127", SUB_MIN, P2_127, 3'd0, 32'h3B00_0000, 5'h00);
        expect_op("R5 1.5*2^-127*2^100", SUB_300, P2_100, 3'd0, 32'h3240_0000, 5'h00);
    endtask

    task automatic test_nan_r6();
        expect_op("R6 nan*1", A_NAN, ONE, 3'd0, 32'h7FC0_0000, 5'h10);
        expect_op("R6 inf*0", P_INF, P_ZERO, 3'd0, 32'h7FC0_0000, 5'h10);
        expect_op("R6 -0*-inf", N_ZERO, N_INF, 3'd3, 32'h7FC0_0000, 5'h10);
    endtask

    task automatic test_overflow_r7();
        expect_op("R7 R9 near-even", P2_127, P2_127, 3'd0, 32'h7F80_0000, 5'h05);
        expect_op("R7 toward zero", P2_127, P2_127, 3'd1, 32'h7F7F_FFFF, 5'h05);
        expect_op("R7 down pos", P2_127, P2_127, 3'd2, 32'h7F7F_FFFF, 5'h05);
        expect_op("R7 down neg", N2_127, P2_127, 3'd2, 32'hFF80_0000, 5'h05);
        expect_op("R7 up neg", N2_127, P2_127, 3'd3, 32'hFF7F_FFFF, 5'h05);
        expect_op("R7 ties away", P2_127, P2_127, 3'd4, 32'h7F80_0000, 5'h05);
    endtask

    task automatic test_underflow_r8();
        expect_op("R8 exact tiny", P2_M63, P2_M64, 3'd0, 32'h0040_0000, 5'h00);
        expect_op("R8 tie even", P2_M75, P2_M75, 3'd0, 32'h0000_0000, 5'h03);
        expect_op("R8 tie up", P2_M75, P2_M75, 3'd3, 32'h0000_0001, 5'h03);
        expect_op("R8 tie away", P2_M75, P2_M75, 3'd4, 32'h0000_0001, 5'h03);
        expect_op("R8 tie toward zero", P2_M75, P2_M75, 3'd1, 32'h0000_0000, 5'h03);
        expect_op("R8 down neg", N2_M75, P2_M75, 3'd2, 32'h8000_0001, 5'h03);
        expect_op("R8 above half even", P1P5_M75, P1P5_M75, 3'd0, 32'h0000_0001, 5'h03);
        expect_op("R8 above half up", P1P5_M75, P1P5_M75, 3'd3, 32'h0000_0002, 5'h03);
        expect_op("R8 sub*sub", SUB_MIN, SUB_MIN, 3'd0, 32'h0000_0000, 5'h03);
        expect_op("R8 sub*sub up", SUB_MIN, SUB_MIN, 3'd3, 32'h0000_0001, 5'h03);
    endtask

    task automatic test_mode_fallback_r10();
        expect_op("R10 mode 7 overflow", P2_127, P2_127, 3'd7, 32'h7F80_0000, 5'h05);
        expect_op("R10 mode 5 tie", P2_M75, P2_M75, 3'd5, 32'h0000_0000, 5'h03);
        expect_op("R10 mode 6 above half", P1P5_M75, P1P5_M75, 3'd6, 32'h0000_0001, 5'h03);
    endtask

    // Single pulse: out_valid high exactly LAT cycles later and only then.
    task automatic test_latency_r3();
        @(negedge clk);
        op_a = ONE_P5; op_b = TWO; rnd_mode = 3'd0; in_valid = 1'b1;
        for (int c = 1; c <= LAT + 1; c++) begin
            @(negedge clk);
            in_valid = 1'b0;
            check_bit($sformatf("R3 out_valid at cycle %0d", c), out_valid, c == LAT);
        end
    endtask

    // Back-to-back stream: new pairs enter while earlier results leave.
    task automatic test_stream_r3();
        logic [31:0] sa [4], sb [4], sr [4];
        logic [2:0]  sm [4];
        logic [4:0]  sf [4];
        sa[0] = ONE_P5; sb[0] = ONE_P5; sm[0] = 3'd0; sr[0] = 32'h4010_0000; sf[0] = 5'h00;
        sa[1] = P2_127; sb[1] = P2_127; sm[1] = 3'd0; sr[1] = 32'h7F80_0000; sf[1] = 5'h05;
        sa[2] = A_NAN;  sb[2] = TWO;    sm[2] = 3'd1; sr[2] = 32'h7FC0_0000; sf[2] = 5'h10;
        sa[3] = P2_M75; sb[3] = P2_M75; sm[3] = 3'd3; sr[3] = 32'h0000_0001; sf[3] = 5'h03;
        for (int j = 0; j < 4 + LAT; j++) begin
            @(negedge clk);
            if (j >= LAT) begin
                check_bit($sformatf("R3 stream valid %0d", j - LAT), out_valid, 1'b1);
                check_bits($sformatf("R3 stream result %0d", j - LAT), result, flags,
                           sr[j - LAT], sf[j - LAT]);
            end
            if (j < 4) begin
                op_a = sa[j]; op_b = sb[j]; rnd_mode = sm[j]; in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        check_bit("R3 stream drained", out_valid, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset_r3();
        test_latency_r3();
        test_normal_r2();
        test_ignore_r1();
        test_sign_r4();
        test_subnormal_in_r5();
        test_nan_r6();
        test_overflow_r7();
        test_underflow_r8();
        test_mode_fallback_r10();
        test_stream_r3();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule